// File: doc/BRIEF.md
# Line Break and Sync-Byte Clock Counter

This block watches a synchronised serial receive line for a break: the line held at a chosen level for a programmed number of nominal bit periods. The break is timed with the receiver's own bit-period tick, which has not yet been matched to the sender. So the threshold sits above the longest run a normal frame can hold and below the shortest break a sender emits. A threshold input of 10 (11 bit periods) falls between the 9 low periods of an ordinary frame and the 13 of a standard LIN break, and leaves room for clock mismatch.

After a qualified break has ended, the block measures the sync byte 0x55 that follows, sent least significant bit first. It counts system clocks from the falling edge of the start bit to the falling edge that opens the last data bit. That span is eight bit periods. It then holds the result so that software can retune the receive bit clock. The start bit plus data bits 1, 3, 5 and 7 give five falling edges at even spacing.

Top module: `lin_sync_detector`

## Requirements
- R1: A break qualifies in the cycle where a tick arrives and the line has equalled the break level for that tick and the `brk_width_i` ticks before it (`brk_width_i`+1 ticks in a row). `brk_pulse_o` is high for exactly the following cycle.
- R2: A line value other than the break level clears the run of ticks. Runs shorter than `brk_width_i`+1 ticks produce no break.
- R3: `brk_level_i` = 0 selects low breaks and 1 selects high breaks. A run at the other level never qualifies.
- R4: A break is reported once, however long it lasts. Sync measurement is armed only once the line has left the break level.
- R5: Once armed, the first falling edge (line 1 then 0) starts the measurement. At the fifth falling edge counting that one, `baud_pulse_o` is high for one cycle, and in the same cycle `clk_count_o` shows the number of clocks between the two edges.
- R6: `clk_count_o` is 0 after reset and changes only together with `baud_pulse_o`.
- R7: If the count reaches its maximum (2^CNT_W-1) without the fifth edge, the measurement is abandoned. There is no baud pulse, the count is unchanged, and the block searches for a break again.
- R8: A break that qualifies while the block is armed or measuring is reported, aborts any measurement without a baud pulse, and re-arms once the line leaves the level.
- R9: While `en_i` is low, both pulses stay low, the run and measurement are discarded, and the block restarts in break search.
- R10: Falling edges seen before any break, or after a completed or abandoned measurement, start no measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Detector enable |
| line_i | input | 1 | Synchronised receive line |
| bit_tick_i | input | 1 | One-cycle pulse per nominal bit period |
| brk_width_i | input | WB | Break threshold minus one, in bit periods |
| brk_level_i | input | 1 | Break level: 0 low, 1 high |
| brk_pulse_o | output | 1 | One-cycle break-detected pulse |
| baud_pulse_o | output | 1 | One-cycle measurement-complete pulse |
| clk_count_o | output | CNT_W | Clocks spanned by the sync byte's eight bit periods |

## Verification
The bench builds the block with CNT_W = 8, so a counter limit of 255 clocks is within reach. With 20-clock bit periods a full sync byte measures 160, and 40-clock bit periods overflow partway through, which exercises the abort path. WB keeps its default of 4, so the default threshold of 11 ticks and a short threshold of 4 ticks can both be driven. EDGES stays at 5, which matches the 0x55 pattern.

// File: rtl/lin_det_pkg.sv
package lin_det_pkg;
   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_RELEASE = 2'd1,
      ST_ARMED   = 2'd2,
      ST_MEASURE = 2'd3
   } det_state_t;
endpackage

// File: rtl/lin_run_qualifier.sv
module lin_run_qualifier #(
   parameter int WB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          act_i,
   input  logic          tick_i,
   input  logic [WB-1:0] width_i,
   output logic          qual_o
);
   localparam int RW = WB + 1;

   logic [RW-1:0] run_q;
   logic [RW-1:0] lim;

   assign lim    = {1'b0, width_i};
   assign qual_o = act_i && tick_i && (run_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (clr_i || !act_i) begin
         run_q <= '0;
      end else if (tick_i && (run_q <= lim)) begin
         run_q <= run_q + RW'(1);
      end
   end

   // R2: a non-trivial threshold can only be met after the level was present
   p_qual_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_o && (width_i != '0)) |-> $past(act_i));
endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer #(
   parameter int CNT_W = 16,
   parameter int EDGES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             clr_i,
   input  logic             fall_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o,
   output logic             full_o
);
   localparam int EW = $clog2(EDGES + 1);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [EW-1:0]    edge_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         edge_q <= '0;
         run_q  <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= '0;
         edge_q <= '0;
         run_q  <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CNT_W'(1);
         edge_q <= EW'(1);
         run_q  <= 1'b1;
      end else if (run_q) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (fall_i) edge_q <= edge_q + EW'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign last_o = run_q && (edge_q == EW'(EDGES - 1));
   assign full_o = run_q && (cnt_q == CMAX);

   // R7: the controller must stop the count before it wraps
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !clr_i && !start_i) |=> (cnt_q != '0));
endmodule

// File: rtl/lin_sync_detector.sv
module lin_sync_detector #(
   parameter int WB    = 4,
   parameter int CNT_W = 16,
   parameter int EDGES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             line_i,
   input  logic             bit_tick_i,
   input  logic [WB-1:0]    brk_width_i,
   input  logic             brk_level_i,
   output logic             brk_pulse_o,
   output logic             baud_pulse_o,
   output logic [CNT_W-1:0] clk_count_o
);
   import lin_det_pkg::*;

   generate
      if (WB < 1) begin : g_bad_wb
         $error("WB must be at least 1");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
      if (EDGES < 2) begin : g_bad_edges
         $error("EDGES must be at least 2");
      end
   endgenerate

   det_state_t       st_q, st_d;
   logic             line_q;
   logic             act, fall, qual;
   logic             brk_q, brk_d, baud_q, baud_d;
   logic             t_start, t_clr, cap;
   logic             t_last, t_full;
   logic [CNT_W-1:0] t_cnt;
   logic [CNT_W-1:0] count_q;

   assign act  = (line_i == brk_level_i);
   assign fall = line_q && !line_i;

   lin_run_qualifier #(.WB(WB)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (!en_i),
      .act_i   (act),
      .tick_i  (bit_tick_i),
      .width_i (brk_width_i),
      .qual_o  (qual)
   );

   lin_sync_timer #(.CNT_W(CNT_W), .EDGES(EDGES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (t_start),
      .clr_i   (t_clr),
      .fall_i  (fall),
      .cnt_o   (t_cnt),
      .last_o  (t_last),
      .full_o  (t_full)
   );

   always_comb begin
      st_d    = st_q;
      brk_d   = 1'b0;
      baud_d  = 1'b0;
      t_start = 1'b0;
      t_clr   = 1'b0;
      cap     = 1'b0;
      if (!en_i) begin
         st_d  = ST_HUNT;
         t_clr = 1'b1;
      end else begin
         unique case (st_q)
            ST_HUNT: begin
               t_clr = 1'b1;
               if (qual) begin
                  brk_d = 1'b1;
                  st_d  = ST_RELEASE;
               end
            end
            ST_RELEASE: begin
               t_clr = 1'b1;
               if (!act) st_d = ST_ARMED;
            end
            ST_ARMED: begin
               if (qual) begin
                  brk_d = 1'b1;
                  t_clr = 1'b1;
                  st_d  = ST_RELEASE;
               end else if (fall) begin
                  t_start = 1'b1;
                  st_d    = ST_MEASURE;
               end
            end
            ST_MEASURE: begin
               if (qual) begin
                  brk_d = 1'b1;
                  t_clr = 1'b1;
                  st_d  = ST_RELEASE;
               end else if (fall && t_last) begin
                  baud_d = 1'b1;
                  cap    = 1'b1;
                  t_clr  = 1'b1;
                  st_d   = ST_HUNT;
               end else if (t_full) begin
                  t_clr = 1'b1;
                  st_d  = ST_HUNT;
               end
            end
            default: st_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_HUNT;
         line_q  <= 1'b1;
         brk_q   <= 1'b0;
         baud_q  <= 1'b0;
         count_q <= '0;
      end else begin
         st_q   <= st_d;
         line_q <= line_i;
         brk_q  <= brk_d;
         baud_q <= baud_d;
         if (cap) count_q <= t_cnt;
      end
   end

   assign brk_pulse_o  = brk_q;
   assign baud_pulse_o = baud_q;
   assign clk_count_o  = count_q;

   // R1: a break pulse follows a tick taken at the break level
   p_brk_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse_o |-> ($past(bit_tick_i) && ($past(line_i) == $past(brk_level_i))));
   // R4: one pulse per break
   p_brk_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse_o |=> !brk_pulse_o);
   // R5: a baud pulse only closes an active measurement
   p_baud_from_meas_r5: assert property (@(posedge clk) disable iff (!rst_n)
      baud_pulse_o |-> ($past(st_q) == ST_MEASURE));
   // R6: the count moves only with the baud pulse
   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_pulse_o |-> $stable(clk_count_o));
   // R8: the two pulses never coincide
   p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_pulse_o && baud_pulse_o));
   // R9: no pulse follows a disabled cycle
   p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!brk_pulse_o && !baud_pulse_o));
endmodule

// File: tb/sim_lin_sync_detector.sv
module sim_lin_sync_detector;
   localparam int CLK_P  = 10;
   localparam int WB     = 4;
   localparam int CNT_W  = 8;
   localparam int EDGES  = 5;
   localparam int TICK_P = 20;
   localparam int MAXC   = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic             line = 1'b1;
   logic             tick = 1'b0;
   logic [WB-1:0]    width = 4'd10;
   logic             level = 1'b0;
   logic             brk_pulse, baud_pulse;
   logic [CNT_W-1:0] clk_count;

   int checks = 0, fails = 0;
   int tcnt = 0;
   int brk_seen = 0, baud_seen = 0;
   bit done = 0;

   // reference model state
   int m_cyc = 0, m_run = 0, m_ph = 0, m_cnt = 0;
   int m_brk = 0, m_baud = 0;
   bit m_prev = 1;
   int edge_t[$];

   always #(CLK_P/2) clk = ~clk;

   lin_sync_detector #(.WB(WB), .CNT_W(CNT_W), .EDGES(EDGES)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .line_i(line), .bit_tick_i(tick),
      .brk_width_i(width), .brk_level_i(level), .brk_pulse_o(brk_pulse),
      .baud_pulse_o(baud_pulse), .clk_count_o(clk_count));

   // behavioural model: phases 0 search, 1 wait for release, 2 armed, 3 measuring
   always @(posedge clk) begin
      bit act, fall, q;
      int w;
      m_cyc++;
      if (!rst_n) begin
         m_run = 0; m_ph = 0; m_cnt = 0; m_brk = 0; m_baud = 0; m_prev = 1;
         edge_t.delete();
      end else if (!en) begin
         m_run = 0; m_ph = 0; m_brk = 0; m_baud = 0; m_prev = line;
         edge_t.delete();
      end else begin
         w    = int'(width);
         act  = (line == level);
         fall = m_prev && !line;
         q    = act && tick && (m_run == w);
         m_brk = 0; m_baud = 0;
         if (!act) m_run = 0;
         else if (tick && m_run < w + 1) m_run++;
         if (m_ph == 0) begin
            if (q) begin m_brk = 1; m_ph = 1; end
         end else if (m_ph == 1) begin
            if (!act) m_ph = 2;
         end else if (m_ph == 2) begin
            if (q) begin m_brk = 1; m_ph = 1; end
            else if (fall) begin
               edge_t.delete(); edge_t.push_back(m_cyc); m_ph = 3;
            end
         end else begin
            if (q) begin m_brk = 1; m_ph = 1; end
            else begin
               if (fall) edge_t.push_back(m_cyc);
               if (fall && edge_t.size() == EDGES) begin
                  m_baud = 1; m_cnt = m_cyc - edge_t[0]; m_ph = 0;
               end else if (m_cyc - edge_t[0] >= MAXC) m_ph = 0;
            end
         end
         m_prev = line;
      end
   end

   task automatic chk(input string tag, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
      end
   endtask

   // one clock: compare outputs, then drive next line value and tick
   task automatic step(input logic v);
      @(negedge clk);
      if (rst_n) begin
         chk("R1 brk_pulse vs model", int'(brk_pulse), m_brk);
         chk("R5 baud_pulse vs model", int'(baud_pulse), m_baud);
         chk("R6 clk_count vs model", int'(clk_count), m_cnt);
         if (brk_pulse) brk_seen++;
         if (baud_pulse) baud_seen++;
      end
      line = v;
      tick = (tcnt == TICK_P - 1);
      tcnt = (tcnt == TICK_P - 1) ? 0 : tcnt + 1;
   endtask

   task automatic hold(input logic v, input int n);
      for (int i = 0; i < n; i++) step(v);
   endtask

   task automatic send_sync(input int p);
      logic [7:0] b = 8'h55;
      hold(1'b0, p);
      for (int i = 0; i < 8; i++) hold(b[i], p);
      hold(1'b1, p);
   endtask

   task automatic window_start(output int b0, output int d0);
      b0 = brk_seen; d0 = baud_seen;
   endtask

   initial begin
      int b0, d0;
      repeat (5) @(negedge clk);
      chk("R1 brk_pulse in reset", int'(brk_pulse), 0);
      chk("R5 baud_pulse in reset", int'(baud_pulse), 0);
      chk("R6 clk_count in reset", int'(clk_count), 0);
      rst_n = 1'b1; en = 1'b1;
      hold(1'b1, 40);

      // R10: a sync pattern with no break before it
      window_start(b0, d0);
      send_sync(20); hold(1'b1, 100);
      chk("R10 baud pulses without break", baud_seen - d0, 0);

      // R2: a low run of at most 9 ticks
      window_start(b0, d0);
      hold(1'b0, 180); hold(1'b1, 100);
      chk("R2 short low run breaks", brk_seen - b0, 0);

      // R1 and R5: break then sync at 20 clocks per bit
      window_start(b0, d0);
      hold(1'b0, 300); hold(1'b1, 60);
      send_sync(20); hold(1'b1, 100);
      chk("R1 break pulses", brk_seen - b0, 1);
      chk("R5 baud pulses", baud_seen - d0, 1);
      chk("R5 measured count", int'(clk_count), 160);

      // R4: a very long break reported once
      window_start(b0, d0);
      hold(1'b0, 400); hold(1'b1, 60);
      chk("R4 long break pulses", brk_seen - b0, 1);

      // R7: break then sync too slow for the counter
      window_start(b0, d0);
      hold(1'b0, 300); hold(1'b1, 60);
      send_sync(40); hold(1'b1, 100);
      chk("R7 baud pulses on overflow", baud_seen - d0, 0);
      chk("R7 count kept on overflow", int'(clk_count), 160);

      // R8: a new break in the middle of a measurement
      window_start(b0, d0);
      hold(1'b0, 300); hold(1'b1, 60);
      hold(1'b0, 20); hold(1'b1, 20); hold(1'b0, 300); hold(1'b1, 60);
      chk("R8 break pulses", brk_seen - b0, 2);
      chk("R8 baud pulses", baud_seen - d0, 0);

      // R9: enable dropped during a measurement
      window_start(b0, d0);
      hold(1'b0, 20); hold(1'b1, 20);
      en = 1'b0; hold(1'b0, 20); en = 1'b1;
      hold(1'b1, 20); hold(1'b0, 20); hold(1'b1, 20); hold(1'b0, 20); hold(1'b1, 60);
      chk("R9 pulses after disable", (brk_seen - b0) + (baud_seen - d0), 0);
      chk("R6 count held", int'(clk_count), 160);

      // R6: a second measurement at 15 clocks per bit
      window_start(b0, d0);
      hold(1'b0, 300); hold(1'b1, 60);
      send_sync(15); hold(1'b1, 100);
      chk("R6 new count", int'(clk_count), 120);
      chk("R6 baud pulses", baud_seen - d0, 1);

      // R3: high-level break, then a long low that must not qualify
      window_start(b0, d0);
      level = 1'b1;
      hold(1'b1, 300); hold(1'b0, 40); hold(1'b1, 20);
      send_sync(20); hold(1'b1, 20);
      hold(1'b0, 300); hold(1'b1, 20);
      level = 1'b0;
      hold(1'b1, 40);
      chk("R3 high break pulses", brk_seen - b0, 1);
      chk("R3 count after high break", int'(clk_count), 160);

      // R1 boundary: threshold of 4 ticks
      width = 4'd3;
      window_start(b0, d0);
      hold(1'b0, 50); hold(1'b1, 60);
      chk("R2 run below short threshold", brk_seen - b0, 0);
      hold(1'b0, 100); hold(1'b1, 60);
      chk("R1 short threshold break", brk_seen - b0, 1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule